// File: doc/BRIEF.md
# MSI Event Queue Writer

This block takes message-signalled interrupt writes (an address and a 16-bit payload) and turns each one into a 32-bit entry in one of several circular event queues kept in host memory. The address of the incoming write picks the queue. The block writes the entry through a simple memory-write master and waits for that write to complete. Only then does it advance the queue's tail index. Each queue drives its own level interrupt line, which stays high while entries wait to be consumed.

Software uses a small register port. Through it, software sets the memory base and the MSI window base, enables each queue and its interrupt, reads the tail index, and writes back the head index once it has drained entries. A mode input chooses the layout. In the compact layout, queues sit in 4-byte MSI address slots and in 256-byte memory slots of one shared region. In the spread layout, each queue has its own 4 KB MSI window and its own 4 KB memory region. The block handles one MSI write at a time. When the target queue is full, it holds the sender off instead of dropping the write.

Top module: `msi_eventq_writer`

## Requirements
- R1: After reset, every head and tail index is 0, every control bit is 0, the error status is 0, both base registers are 0, `irq` is all zero and `memValid` is low.
- R2: With `multiRegion`=0, the queue index is (msiAddr − msiBase)/4. The entry is written at eqBase + q·256 + tail·4.
- R3: With `multiRegion`=1, the queue index is (msiAddr − msiBase)/4096. The entry is written at eqBase + q·4096 + tail·4.
- R4: The entry carries the MSI payload in bits [15:0] and zero in bits [31:16]. `memValid`, `memAddr` and `memData` stay steady until the cycle in which `memDone` is high.
- R5: A queue's tail index advances by one, modulo 64, in the clock edge that sees `memDone`. An interrupt line can rise only after such a completion or after a register write. Tail is read at byte offset 0x48 + 16·q.
- R6: The control register of queue q sits at byte offset 0x40 + 16·q. Only bit 0 (queue enable), bit 1 (per-event interrupt) and bit 11 (interrupt enable) are stored; every other bit reads 0. `irq[q]` is high exactly when all three bits are set and head ≠ tail.
- R7: The head index of queue q is written and read at byte offset 0x44 + 16·q, and only its low 6 bits are kept. Writes to the tail offset have no effect. eqBase is at 0x00 and msiBase is at 0x04.
- R8: When an enabled queue is full (tail+1 ≡ head mod 64), `msiReady` stays low. The write is taken, not lost, once software moves head.
- R9: A write aimed at a disabled queue is accepted and discarded with no memory write, and it sets bit q of the error status at 0x08. That bit stays set until software writes 1 to it. A new error in the same cycle wins over the clear.
- R10: A write whose computed queue index is 6 or more is accepted and discarded. It causes no memory write and no change of any register.
- R11: `msiReady` is low whenever `memValid` is high, so only one entry is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| multiRegion | input | 1 | 0: compact layout, 1: one 4 KB window and region per queue |
| msiValid | input | 1 | MSI write present |
| msiReady | output | 1 | MSI write taken this cycle |
| msiAddr | input | 32 | MSI write address |
| msiData | input | 16 | MSI payload |
| memValid | output | 1 | Entry write request |
| memAddr | output | 32 | Entry byte address |
| memData | output | 32 | Entry contents |
| memDone | input | 1 | Entry write completed |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| irq | output | 6 | Per-queue interrupt level |

## Verification
The assertions check four things on every cycle:
- the memory request stays steady until it completes;
- no MSI write is accepted while an entry is in flight;
- every memory request begins with an accepted MSI write;
- an interrupt line rises only after a completed entry write or a register write.

The address arithmetic of both layouts can only be shown by the bench's scenarios, which compare against a behavioural model on every clock. The same holds for wrap of the tail index, holding off a write to a full queue until head moves, and discarding writes to disabled or out-of-range queues along with the sticky error bits.

// File: rtl/mqw_pkg.sv
`timescale 1ns/1ps
package mqw_pkg;
  localparam int MAX_Q  = 8;
  localparam int QIDX_W = $clog2(MAX_Q);

  localparam int CTRL_EQ_EN  = 0;
  localparam int CTRL_EVT_IE = 1;
  localparam int CTRL_IRQ_EN = 11;

  typedef struct packed {
    logic              capture;
    logic              discardErr;
    logic              advanceTail;
    logic [QIDX_W-1:0] qIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/mqw_ctrl.sv
`timescale 1ns/1ps
module mqw_ctrl
  import mqw_pkg::*;
#(
  parameter int NUM_Q     = 6,
  parameter int ADDR_W    = 32,
  parameter int SLOT_SH   = 2,
  parameter int REGION_SH = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              multiRegion,
  input  logic              msiValid,
  output logic              msiReady,
  input  logic [ADDR_W-1:0] msiAddr,
  input  logic [ADDR_W-1:0] msiBase,
  input  logic [NUM_Q-1:0]  qEnable,
  input  logic [NUM_Q-1:0]  qFull,
  output logic              memValid,
  input  logic              memDone,
  output ctrlStrobe_t       strobe
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] qRaw;
  logic              inRange;
  logic [QIDX_W-1:0] qSel;
  logic [QIDX_W-1:0] qHeld;
  logic [MAX_Q-1:0]  enPad;
  logic [MAX_Q-1:0]  fullPad;
  logic              selEn;
  logic              busy;
  logic              accept;

  always_comb begin
    offset  = msiAddr - msiBase;
    qRaw    = multiRegion ? (offset >> REGION_SH) : (offset >> SLOT_SH);
    inRange = qRaw < ADDR_W'(NUM_Q);
    qSel    = qRaw[QIDX_W-1:0];
    enPad   = MAX_Q'(qEnable);
    fullPad = MAX_Q'(qFull);
    selEn   = inRange && enPad[qSel];
    accept  = msiValid && !busy && !(selEn && fullPad[qSel]);
  end

  assign msiReady = accept;
  assign memValid = busy;

  always_comb begin
    strobe.capture     = accept && selEn;
    strobe.discardErr  = accept && inRange && !enPad[qSel];
    strobe.advanceTail = busy && memDone;
    strobe.qIdx        = busy ? qHeld : qSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy  <= 1'b0;
      qHeld <= '0;
    end else if (strobe.capture) begin
      busy  <= 1'b1;
      qHeld <= qSel;
    end else if (strobe.advanceTail) begin
      busy  <= 1'b0;
    end
  end
endmodule

// File: rtl/mqw_dpath.sv
`timescale 1ns/1ps
module mqw_dpath
  import mqw_pkg::*;
#(
  parameter int NUM_Q     = 6,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 16,
  parameter int ENTRY_W   = 32,
  parameter int PTR_W     = 6,
  parameter int REG_AW    = 8,
  parameter int REGION_SH = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               multiRegion,
  input  logic [DATA_W-1:0]  msiData,
  input  ctrlStrobe_t        strobe,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  output logic [ADDR_W-1:0]  msiBase,
  output logic [NUM_Q-1:0]   qEnable,
  output logic [NUM_Q-1:0]   qFull,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memData,
  output logic [NUM_Q-1:0]   irq
);
  localparam int ENTRY_SH  = $clog2(ENTRY_W / 8);
  localparam int QSTRIDE_SH = PTR_W + ENTRY_SH;
  localparam int RIDX_W    = REG_AW - 4;
  localparam logic [REG_AW-1:0] A_EQBASE  = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] A_MSIBASE = REG_AW'(8'h04);
  localparam logic [REG_AW-1:0] A_ERR     = REG_AW'(8'h08);
  localparam logic [REG_AW-1:0] A_QBASE   = REG_AW'(8'h40);

  logic [ADDR_W-1:0] eqBase;
  logic [NUM_Q-1:0]  errQ, enQ, evtQ, ieQ;
  logic [PTR_W-1:0]  headQ [NUM_Q];
  logic [PTR_W-1:0]  tailQ [NUM_Q];

  logic [REG_AW-1:0] rel;
  logic [RIDX_W-1:0] rIdx;
  logic [1:0]        rFld;
  logic              isQ;
  logic [PTR_W-1:0]  tailSel;
  logic [ADDR_W-1:0] qOff;
  logic [NUM_Q-1:0]  errSet, errClr;

  always_comb begin
    rel  = regAddr - A_QBASE;
    rIdx = rel[REG_AW-1:4];
    rFld = rel[3:2];
    isQ  = (regAddr >= A_QBASE) && (int'(rIdx) < NUM_Q) && (rel[1:0] == 2'b00);
    tailSel = '0;
    for (int q = 0; q < NUM_Q; q++)
      if (strobe.qIdx == QIDX_W'(q)) tailSel = tailQ[q];
    qOff   = multiRegion ? (ADDR_W'(strobe.qIdx) << REGION_SH)
                         : (ADDR_W'(strobe.qIdx) << QSTRIDE_SH);
    errSet = strobe.discardErr ? (NUM_Q'(1) << strobe.qIdx) : '0;
    errClr = (regWe && regAddr == A_ERR) ? regWdata[NUM_Q-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eqBase  <= '0;
      msiBase <= '0;
      errQ    <= '0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      if (regWe && regAddr == A_EQBASE)  eqBase  <= ADDR_W'(regWdata);
      if (regWe && regAddr == A_MSIBASE) msiBase <= ADDR_W'(regWdata);
      errQ <= (errQ & ~errClr) | errSet;
      if (strobe.capture) begin
        memAddr <= eqBase + qOff + (ADDR_W'(tailSel) << ENTRY_SH);
        memData <= ENTRY_W'(msiData);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      evtQ <= '0;
      ieQ  <= '0;
      for (int q = 0; q < NUM_Q; q++) begin
        headQ[q] <= '0;
        tailQ[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (regWe && isQ && rIdx == RIDX_W'(q)) begin
          if (rFld == 2'd0) begin
            enQ[q]  <= regWdata[CTRL_EQ_EN];
            evtQ[q] <= regWdata[CTRL_EVT_IE];
            ieQ[q]  <= regWdata[CTRL_IRQ_EN];
          end else if (rFld == 2'd1) begin
            headQ[q] <= regWdata[PTR_W-1:0];
          end
        end
        if (strobe.advanceTail && strobe.qIdx == QIDX_W'(q))
          tailQ[q] <= tailQ[q] + 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_Q; g++) begin : gQueue
      assign qEnable[g] = enQ[g];
      assign qFull[g]   = (PTR_W'(tailQ[g] + 1'b1) == headQ[g]);
      assign irq[g]     = enQ[g] && evtQ[g] && ieQ[g] && (headQ[g] != tailQ[g]);
    end
  endgenerate

  always_comb begin
    regRdata = '0;
    if (regAddr == A_EQBASE)       regRdata = 32'(eqBase);
    else if (regAddr == A_MSIBASE) regRdata = 32'(msiBase);
    else if (regAddr == A_ERR)     regRdata = 32'(errQ);
    else if (isQ) begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (rIdx == RIDX_W'(q)) begin
          if (rFld == 2'd0) begin
            regRdata[CTRL_EQ_EN]  = enQ[q];
            regRdata[CTRL_EVT_IE] = evtQ[q];
            regRdata[CTRL_IRQ_EN] = ieQ[q];
          end else if (rFld == 2'd1) regRdata = 32'(headQ[q]);
          else if (rFld == 2'd2)     regRdata = 32'(tailQ[q]);
        end
      end
    end
  end
endmodule

// File: rtl/msi_eventq_writer.sv
`timescale 1ns/1ps
module msi_eventq_writer
  import mqw_pkg::*;
#(
  parameter int NUM_Q  = 6,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int PTR_W  = 6,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              multiRegion,
  input  logic              msiValid,
  output logic              msiReady,
  input  logic [ADDR_W-1:0] msiAddr,
  input  logic [DATA_W-1:0] msiData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  input  logic              memDone,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [NUM_Q-1:0]  irq
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] msiBase;
  logic [NUM_Q-1:0]  qEnable, qFull;

  mqw_ctrl #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .multiRegion, .msiValid, .msiReady, .msiAddr,
    .msiBase, .qEnable, .qFull, .memValid, .memDone, .strobe
  );

  mqw_dpath #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRY_W(32),
              .PTR_W(PTR_W), .REG_AW(REG_AW)) u_dpath (
    .clk, .rstN, .multiRegion, .msiData, .strobe, .regWe, .regAddr,
    .regWdata, .regRdata, .msiBase, .qEnable, .qFull, .memAddr, .memData, .irq
  );
endmodule

// File: rtl/mqw_checker.sv
`timescale 1ns/1ps
module mqw_checker #(
  parameter int NUM_Q  = 6,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              msiValid,
  input logic              msiReady,
  input logic              memValid,
  input logic              memDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memData,
  input logic              regWe,
  input logic [NUM_Q-1:0]  irq
);
  p_mem_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memDone |=> memValid && $stable(memAddr) && $stable(memData));

  p_single_flight_r11: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !msiReady);

  p_irq_after_publish_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(irq & ~$past(irq))) |-> ($past(memValid && memDone) || $past(regWe)));

  p_req_from_msi_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> $past(msiValid && msiReady));
endmodule

bind msi_eventq_writer mqw_checker #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .msiValid(msiValid), .msiReady(msiReady),
  .memValid(memValid), .memDone(memDone), .memAddr(memAddr), .memData(memData),
  .regWe(regWe), .irq(irq)
);

// File: tb/tb_msi_eventq_writer.sv
`timescale 1ns/1ps
module tb_msi_eventq_writer;
  localparam int NQ = 6;
  localparam logic [31:0] EQB = 32'h8000_0000;
  localparam logic [31:0] MSB = 32'h1000_0000;

  logic clk = 0, rstN = 0, multiRegion = 0;
  logic msiValid = 0, msiReady;
  logic [31:0] msiAddr = '0;
  logic [15:0] msiData = '0;
  logic memValid, memDone = 0;
  logic [31:0] memAddr, memData;
  logic regWe = 0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [NQ-1:0] irq;

  msi_eventq_writer dut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit started = 0;

  // behavioural reference state
  logic [31:0] mEqBase, mMsiBase, mAddr, mData;
  logic [31:0] mCtrl [NQ];
  int mHead [NQ], mTail [NQ];
  logic [NQ-1:0] mErr;
  bit mBusy, mMulti;
  int mQ;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit decodeQ(logic [31:0] a, output int q);
    logic [31:0] off = a - mMsiBase;
    q = multiRegion ? int'(off / 4096) : int'(off / 4);
    return off / (multiRegion ? 4096 : 4) < NQ;
  endfunction

  function automatic bit predReady();
    int q;
    bit inR = decodeQ(msiAddr, q);
    if (!msiValid || mBusy) return 0;
    if (inR && mCtrl[q][0] && ((mTail[q] + 1) % 64 == mHead[q])) return 0;
    return 1;
  endfunction

  function automatic logic [NQ-1:0] predIrq();
    logic [NQ-1:0] v = '0;
    for (int q = 0; q < NQ; q++)
      v[q] = (mCtrl[q] == 32'h803) && (mHead[q] != mTail[q]);
    return v;
  endfunction

  function automatic logic [31:0] predRd(logic [7:0] a);
    int q, f;
    if (a == 8'h00) return mEqBase;
    if (a == 8'h04) return mMsiBase;
    if (a == 8'h08) return 32'(mErr);
    if (a >= 8'h40 && a < 8'h40 + 16 * NQ && a[1:0] == 0) begin
      q = (int'(a) - 'h40) / 16;
      f = (int'(a) / 4) % 4;
      if (f == 0) return mCtrl[q];
      if (f == 1) return 32'(mHead[q]);
      if (f == 2) return 32'(mTail[q]);
    end
    return 0;
  endfunction

  function automatic string rdTag(logic [7:0] a);
    if (a == 8'h08) return "R9 errStatus";
    if (a >= 8'h40 && ((int'(a) / 4) % 4) == 2) return "R5 tailRead";
    if (a >= 8'h40 && ((int'(a) / 4) % 4) == 0) return "R6 ctrlRead";
    return "R7 regRead";
  endfunction

  // model update at the clock edge
  always @(posedge clk) begin
    if (!rstN) begin
      mEqBase = 0; mMsiBase = 0; mErr = 0; mBusy = 0; mMulti = 0; mQ = 0;
      mAddr = 0; mData = 0;
      for (int q = 0; q < NQ; q++) begin mCtrl[q] = 0; mHead[q] = 0; mTail[q] = 0; end
    end else begin
      automatic int q;
      automatic bit inR = decodeQ(msiAddr, q);
      automatic bit rdy = predReady();
      automatic logic [NQ-1:0] setE = '0;
      if (mBusy && memDone) begin
        mTail[mQ] = (mTail[mQ] + 1) % 64;
        mBusy = 0;
      end
      if (rdy && inR) begin
        if (mCtrl[q][0]) begin
          mBusy = 1; mQ = q; mMulti = multiRegion;
          mAddr = mEqBase + 32'(q * (multiRegion ? 4096 : 256)) + 32'(mTail[q] * 4);
          mData = {16'h0, msiData};
        end else setE[q] = 1'b1;
      end
      if (regWe) begin
        if (regAddr == 8'h00) mEqBase = regWdata;
        else if (regAddr == 8'h04) mMsiBase = regWdata;
        else if (regAddr == 8'h08) mErr = mErr & ~regWdata[NQ-1:0];
        else if (regAddr >= 8'h40 && regAddr < 8'h40 + 16 * NQ && regAddr[1:0] == 0) begin
          automatic int rq = (int'(regAddr) - 'h40) / 16;
          automatic int f = (int'(regAddr) / 4) % 4;
          if (f == 0) mCtrl[rq] = regWdata & 32'h803;
          else if (f == 1) mHead[rq] = int'(regWdata % 64);
        end
      end
      mErr = mErr | setE;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && started) begin
      chk("R8 msiReady", 32'(msiReady), 32'(predReady()));
      chk("R11 memValid", 32'(memValid), 32'(mBusy));
      if (mBusy) begin
        chk(mMulti ? "R3 memAddr" : "R2 memAddr", memAddr, mAddr);
        chk("R4 memData", memData, mData);
      end
      chk("R6 irq", 32'(irq), 32'(predIrq()));
      chk(rdTag(regAddr), regRdata, predRd(regAddr));
    end
  end

  // memory responder with varying latency
  int lcnt = 0, lat = 0;
  always @(posedge clk) begin
    #1;
    if (memDone) memDone = 0;
    else if (memValid) begin
      if (lcnt >= lat) begin memDone = 1; lcnt = 0; lat = (lat + 1) % 4; end
      else lcnt++;
    end
  end

  task automatic regWrite(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic setRead(logic [7:0] a);
    @(posedge clk); #1;
    regAddr = a;
  endtask

  task automatic sendMsi(logic [31:0] a, logic [15:0] d);
    @(posedge clk); #1;
    msiValid = 1; msiAddr = a; msiData = d;
    forever begin
      @(negedge clk);
      if (msiReady) break;
    end
    @(posedge clk); #1;
    msiValid = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (memValid);
  endtask

  function automatic logic [7:0] qReg(int q, int f);
    return 8'(8'h40 + 16 * q + 4 * f);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    started = 1;
    @(negedge clk);
    chk("R1 irq reset", 32'(irq), 0);
    chk("R1 memValid reset", 32'(memValid), 0);
    for (int q = 0; q < NQ; q++) begin
      for (int f = 0; f < 3; f++) begin
        setRead(qReg(q, f));
        @(negedge clk);
        chk("R1 queue reg reset", regRdata, 0);
      end
    end

    regWrite(8'h00, EQB);
    regWrite(8'h04, MSB);
    for (int q = 0; q < NQ; q++)
      if (q != 4) regWrite(qReg(q, 0), (q == 3) ? 32'h801 : 32'h803);
    regWrite(qReg(2, 0), 32'hFFFF_FFFF);
    setRead(qReg(2, 0));
    @(negedge clk);
    chk("R6 ctrl mask", regRdata, 32'h803);

    // compact layout
    sendMsi(MSB + 0, 16'h1234);
    @(negedge clk);
    chk("R2 q0 address", memAddr, EQB);
    chk("R4 q0 data", memData, 32'h0000_1234);
    waitIdle();
    @(negedge clk);
    chk("R6 q0 irq up", 32'(irq[0]), 1);
    sendMsi(MSB + 8, 16'hBEEF);
    @(negedge clk);
    chk("R2 q2 address", memAddr, EQB + 32'h200);
    waitIdle();
    sendMsi(MSB + 20, 16'h0005);
    @(negedge clk);
    chk("R2 q5 address", memAddr, EQB + 32'h500);
    waitIdle();
    sendMsi(MSB + 12, 16'h3333);
    waitIdle();
    @(negedge clk);
    chk("R6 q3 no irq without per-event bit", 32'(irq[3]), 0);
    for (int i = 0; i < 2; i++) begin sendMsi(MSB + 4, 16'(16'h100 + i)); waitIdle(); end

    // drain q0
    regWrite(qReg(0, 1), 32'h41);
    @(negedge clk);
    chk("R6 q0 irq dropped", 32'(irq[0]), 0);
    setRead(qReg(0, 1));
    @(negedge clk);
    chk("R7 head keeps 6 bits", regRdata, 1);

    // tail writes ignored
    regWrite(qReg(0, 2), 32'h15);
    setRead(qReg(0, 2));
    @(negedge clk);
    chk("R7 tail write ignored", regRdata, 1);

    // disabled queue and out-of-range slot
    setRead(8'h08);
    sendMsi(MSB + 16, 16'hDEAD);
    @(negedge clk);
    chk("R9 no write for disabled queue", 32'(memValid), 0);
    chk("R9 error bit set", regRdata, 32'h10);
    sendMsi(MSB + 24, 16'hAAAA);
    @(negedge clk);
    chk("R10 out of range no write", 32'(memValid), 0);
    chk("R10 out of range no error", regRdata, 32'h10);
    regWrite(8'h08, 32'h10);
    @(negedge clk);
    chk("R9 error cleared by write-one", regRdata, 0);

    // fill q1, hold off, wrap
    t = mTail[1];
    regWrite(qReg(1, 1), 32'(t));
    for (int i = 0; i < 63; i++) begin sendMsi(MSB + 4, 16'(i)); waitIdle(); end
    fork
      sendMsi(MSB + 4, 16'h7777);
      begin
        repeat (6) begin
          @(negedge clk);
          chk("R8 full queue holds off", 32'(msiReady), 0);
        end
        regWrite(qReg(1, 1), 32'((t + 1) % 64));
      end
    join
    waitIdle();
    setRead(qReg(1, 2));
    @(negedge clk);
    chk("R5 tail wrapped", regRdata, 32'((t + 64) % 64));

    // spread layout
    multiRegion = 1;
    sendMsi(MSB + 32'h2010, 16'h4242);
    @(negedge clk);
    chk("R3 q2 address", memAddr, EQB + 32'h2004);
    waitIdle();
    sendMsi(MSB + 32'h5000, 16'h0001);
    @(negedge clk);
    chk("R3 q5 address", memAddr, EQB + 32'h5004);
    waitIdle();
    sendMsi(MSB + 32'h6000, 16'h0002);
    @(negedge clk);
    chk("R10 spread out of range", 32'(memValid), 0);
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule